// File: doc/BRIEF.md
# Chip-Select Kicked Watchdog Timer

This block is a watchdog counter that advances on a slow oscillator tick. A transition on a serial chip-select line clears it, and the direction of the transition does not matter. If the count runs out before any transition arrives, the block raises a single-cycle timeout request for the reset controller, which then drives both reset outputs.

The counter stays cleared while any of three conditions holds:

- the supply is not yet good;
- the power-on reset period is still running;
- an external reset is asserted.

Counting starts only when the last of these conditions goes away, so the release comes at whichever is later: the end of the power-on period or the release of the external reset.

After a timeout the block counts no further. It waits until the resulting reset appears as one of the hold conditions. When that reset ends, the block starts again from zero. Chip-select is synchronised to the system clock before its edges are detected. The tick is a one-clock-wide strobe that is already in the system clock domain.

Top module: `csKickWatchdog`

## Requirements
- R1: Once the hold is released, timeoutPulse goes high for one clock in the cycle after the TIMEOUT_TICKS-th tick, provided no chip-select transition and no hold occurred in that window.
- R2: A rising transition on csIn restarts the count from zero, so that TIMEOUT_TICKS further ticks are needed for a timeout.
- R3: A falling transition on csIn restarts the count from zero in the same way as a rising one.
- R4: While supplyGood is low, the count is held at zero and no timeout is produced. A drop of supplyGood in the middle of a count discards the ticks already counted.
- R5: While porActive is high, the count is held at zero and no timeout is produced.
- R6: While extResetActive is high, the count is held at zero. Counting resumes only once both porActive and extResetActive are low, whichever of them falls last.
- R7: After a timeout, ticks are ignored until a hold condition has been seen and released. Counting then restarts from zero.
- R8: timeoutPulse is never high for two consecutive clocks.
- R9: While rstN is low, and directly after it is released, timeoutPulse is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock strobe from the slow oscillator |
| csIn | input | 1 | Serial chip-select, asynchronous to clk |
| supplyGood | input | 1 | High when the supply is above its trip level |
| porActive | input | 1 | High while the power-on reset period is running |
| extResetActive | input | 1 | High while an external reset input is asserted |
| timeoutPulse | output | 1 | One-clock timeout request to the reset controller |

## Verification
The bench builds the block with TIMEOUT_TICKS = 5 and SYNC_STAGES = 2. The short limit makes a full expiry, a kick one tick before expiry, and the refusal to count again after a timeout all reachable within a few dozen ticks. With two sync stages, a chip-select toggle settles within four clocks, so every tick spaced four clocks apart lands on a well-defined count. Each hold input is exercised on its own and in overlap, including the order in which they are released.

// File: rtl/wdPkg.sv
package wdPkg;

  // Strobes issued by the control to the datapath
  typedef struct packed {
    logic clearCnt;
    logic countEn;
  } wdStrobeT;

  // Status returned by the datapath
  typedef struct packed {
    logic csEdge;
    logic atLimit;
  } wdStatusT;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FIRED = 2'd2,
    ST_WAIT  = 2'd3
  } wdStateT;

endpackage

// File: rtl/wdDatapath.sv
module wdDatapath
  import wdPkg::*;
#(
  parameter int TIMEOUT_TICKS = 8000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     csIn,
  input  wdStrobeT strobe,
  output wdStatusT status
);

  localparam int CNT_W = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TIMEOUT_TICKS - 1);

  logic [SYNC_STAGES-1:0] csSync;
  logic                   csPrev;
  logic [CNT_W-1:0]       tickCnt;

  // Synchroniser chain for chip-select
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) csSync <= '0;
        else       csSync <= csIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) csSync <= '0;
        else       csSync <= {csSync[SYNC_STAGES-2:0], csIn};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) csPrev <= 1'b0;
    else       csPrev <= csSync[SYNC_STAGES-1];
  end

  // Tick counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 tickCnt <= '0;
    else if (strobe.clearCnt)  tickCnt <= '0;
    else if (strobe.countEn)   tickCnt <= tickCnt + 1'b1;
  end

  always_comb begin
    status.csEdge  = csSync[SYNC_STAGES-1] ^ csPrev;
    status.atLimit = (tickCnt == LAST_CNT);
  end

  assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt <= LAST_CNT);

  assert_clear_to_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearCnt |=> (tickCnt == '0));

endmodule

// File: rtl/wdControl.sv
module wdControl
  import wdPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     tick,
  input  logic     supplyGood,
  input  logic     porActive,
  input  logic     extResetActive,
  input  wdStatusT status,
  output wdStrobeT strobe,
  output logic     timeoutPulse
);

  wdStateT state, stateNext;
  logic    holdReq;

  // Any hold source keeps the watchdog cleared; release follows the latest one
  assign holdReq = !supplyGood || porActive || extResetActive;

  always_comb begin
    stateNext       = state;
    strobe.clearCnt = 1'b1;
    strobe.countEn  = 1'b0;
    unique case (state)
      ST_HOLD: begin
        if (!holdReq) stateNext = ST_RUN;
      end
      ST_RUN: begin
        if (holdReq) begin
          stateNext = ST_HOLD;
        end else if (status.csEdge) begin
          strobe.clearCnt = 1'b1;
        end else if (tick && status.atLimit) begin
          stateNext = ST_FIRED;
        end else begin
          strobe.clearCnt = 1'b0;
          strobe.countEn  = tick;
        end
      end
      ST_FIRED: begin
        stateNext = holdReq ? ST_HOLD : ST_WAIT;
      end
      ST_WAIT: begin
        if (holdReq) stateNext = ST_HOLD;
      end
      default: stateNext = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_HOLD;
    else       state <= stateNext;
  end

  assign timeoutPulse = (state == ST_FIRED);

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |=> !timeoutPulse);

  assert_hold_blocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    holdReq |=> !timeoutPulse);

  assert_wait_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |=> !timeoutPulse);

  assert_fire_needs_tick_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutPulse) |-> $past(tick));

endmodule

// File: rtl/csKickWatchdog.sv
module csKickWatchdog
  import wdPkg::*;
#(
  parameter int TIMEOUT_TICKS = 8000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic csIn,
  input  logic supplyGood,
  input  logic porActive,
  input  logic extResetActive,
  output logic timeoutPulse
);

  wdStrobeT strobe;
  wdStatusT status;

  wdDatapath #(
    .TIMEOUT_TICKS(TIMEOUT_TICKS),
    .SYNC_STAGES  (SYNC_STAGES)
  ) uDatapath (
    .clk   (clk),
    .rstN  (rstN),
    .csIn  (csIn),
    .strobe(strobe),
    .status(status)
  );

  wdControl uControl (
    .clk           (clk),
    .rstN          (rstN),
    .tick          (tick),
    .supplyGood    (supplyGood),
    .porActive     (porActive),
    .extResetActive(extResetActive),
    .status        (status),
    .strobe        (strobe),
    .timeoutPulse  (timeoutPulse)
  );

  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rstN |=> !timeoutPulse);

endmodule

// File: tb/sim_csKickWatchdog.sv
module sim_csKickWatchdog;

  localparam int LIMIT = 5;

  typedef struct {
    bit    exp;
    string tag;
  } expItemT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic csIn = 1'b0;
  logic supplyGood = 1'b0;
  logic porActive = 1'b0;
  logic extResetActive = 1'b0;
  logic timeoutPulse;
  logic tickD = 1'b0;

  int checks = 0;
  int errors = 0;
  int modelCnt = 0;
  bit armed = 1'b1;
  bit running = 1'b0;
  bit done = 1'b0;
  expItemT expQ[$];

  always #4 clk = ~clk;

  csKickWatchdog #(.TIMEOUT_TICKS(LIMIT), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .csIn(csIn),
    .supplyGood(supplyGood), .porActive(porActive),
    .extResetActive(extResetActive), .timeoutPulse(timeoutPulse)
  );

  task automatic check(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: timeoutPulse=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) tickD <= tick;

  // Monitor: compares the output with the queued expectations
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (tickD) begin
        if (expQ.size() == 0) begin
          check(timeoutPulse, 1'b0, "R1 queue underrun");
        end else begin
          expItemT it;
          it = expQ.pop_front();
          check(timeoutPulse, it.exp, it.tag);
        end
      end else begin
        check(timeoutPulse, 1'b0, "R8");
      end
    end
  end

  // Driver: one tick, with its expected result pushed to the queue
  task automatic doTick(input string tag);
    expItemT it;
    @(negedge clk) tick = 1'b1;
    it.exp = 1'b0;
    it.tag = tag;
    if (running && armed) begin
      modelCnt++;
      if (modelCnt == LIMIT) begin
        it.exp   = 1'b1;
        modelCnt = 0;
        armed    = 1'b0;
      end
    end
    expQ.push_back(it);
    @(negedge clk) tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) doTick(tag);
  endtask

  task automatic setHold(input bit sg, input bit por, input bit ext);
    @(negedge clk);
    supplyGood     = sg;
    porActive      = por;
    extResetActive = ext;
    running = sg && !por && !ext;
    if (!running) begin
      modelCnt = 0;
      armed    = 1'b1;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic kick();
    @(negedge clk) csIn = ~csIn;
    repeat (4) @(negedge clk);
    modelCnt = 0;
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(timeoutPulse, 1'b0, "R9 during reset");
    rstN = 1'b1;
    @(negedge clk);
    check(timeoutPulse, 1'b0, "R9 after reset");

    ticks(7, "R4 supply low");
    setHold(1, 1, 0);
    ticks(7, "R5 por active");
    setHold(1, 1, 1);
    ticks(2, "R6 both held");
    setHold(1, 0, 1);
    ticks(7, "R6 ext still held");
    setHold(1, 0, 0);
    ticks(5, "R1 expiry");
    ticks(7, "R7 after timeout");

    setHold(1, 1, 0);
    setHold(1, 0, 0);
    ticks(3, "R2 before kick");
    kick();
    ticks(4, "R2 after rising kick");
    ticks(1, "R2 expiry after kick");

    setHold(1, 0, 1);
    setHold(1, 0, 0);
    ticks(4, "R3 before kick");
    kick();
    ticks(4, "R3 after falling kick");
    ticks(1, "R3 expiry after kick");

    setHold(0, 0, 0);
    setHold(1, 0, 0);
    ticks(3, "R4 before drop");
    setHold(0, 0, 0);
    setHold(1, 0, 0);
    ticks(4, "R4 after drop");
    ticks(1, "R4 expiry after drop");

    repeat (3) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R1: %0d expectations left, expected 0", expQ.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule